// File: doc/BRIEF.md
# Shadow Register Reload Controller

This block separates the configuration that software is preparing from the configuration that a display pipeline is currently using. Software writes a bank of shadow registers through a simple register write port. The pipeline sees only the active copy of that bank. The whole bank moves from shadow to active in a single clock edge, so a frame never uses a mix of old and new settings.

Software starts a transfer by writing a two-bit command word. One bit asks for a transfer right away. The other asks for a transfer at the next vertical-blanking strobe. Each request stays pending, and is visible on an output, until the transfer it asks for has happened. When a transfer completes, a reload status flag is set. That flag sits in a small interrupt block together with three external event flags: line event, FIFO underrun and transfer error. The block has an enable register, a sticky status vector and a write-one-to-clear register, and it drives one registered interrupt line. Address decoding for the rest of the peripheral is done elsewhere. This block only compares the local address of each write.

Top module: `shadow_reload_ctrl`

## Requirements
- R1: After a synchronous reset, the active bank, the shadow bank, both pending request bits, all four status bits, the enable bits and `irq_out` are zero.
- R2: A write to shadow register i (address i, for i below NUM_REGS) does not change the active bank until a transfer happens.
- R3: Writing the command word (address NUM_REGS) with bit 0 set makes `reload_pend[0]` read 1 after that write's edge. At the following edge every active register takes its shadow value, and `reload_pend[0]` returns to 0.
- R4: Writing the command word with bit 1 set makes `reload_pend[1]` read 1. The bit holds, and the active bank holds, until a clock edge at which `vblank_pulse` is high. At that edge the bank is copied and the bit clears. A `vblank_pulse` with nothing pending changes nothing.
- R5: A `vblank_pulse` in the same cycle as the command write that requests the blanking transfer does not serve that request. The request waits for a later strobe.
- R6: When both request bits are pending, the immediate transfer happens at the next edge whether or not `vblank_pulse` is high, and it clears both bits.
- R7: A shadow write made while a blanking transfer is pending replaces the value that the transfer will copy.
- R8: A shadow write in the same cycle as a transfer leaves the pre-write shadow value in the active register. The new value stays in the shadow bank for the next transfer.
- R9: Status bit 3 is set by each completed transfer. Status bits 0, 1 and 2 are set by `evt_strobe[0]`, `evt_strobe[1]` and `evt_strobe[2]`. The enable register (address NUM_REGS+1) uses the same bit positions.
- R10: Writing ones to the clear register (address NUM_REGS+2) clears the matching status bits. If a bit is set and cleared in the same cycle, the set wins.
- R11: `irq_out` is registered and equals the OR of (status AND enable) as it stood one cycle earlier. A status bit still sets while its enable is clear.
- R12: Command bits are write-one-to-set. A command write with both bits zero neither starts a transfer nor cancels a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Local register address |
| wr_data | input | DATA_W | Write data |
| vblank_pulse | input | 1 | One-cycle vertical-blanking strobe |
| evt_strobe | input | 3 | Line event, FIFO underrun and transfer error strobes (bits 0, 1, 2) |
| active_flat | output | NUM_REGS*DATA_W | Active bank; register i is in bits [i*DATA_W +: DATA_W] |
| reload_pend | output | 2 | Pending requests: bit 0 immediate, bit 1 at blanking |
| irq_status | output | 4 | Sticky status: line, underrun, transfer error, reload done |
| irq_out | output | 1 | Registered interrupt line |

## Verification
Two pairs of actions can fall on the same clock edge, and the bench provokes both deliberately. The first pair is a blanking-strobe transfer and a software write to the shadow register being copied. The bench drives both in one cycle and then checks that the active register holds the pre-write value while the new value is only published by a later immediate transfer. The second pair is an event strobe and a write-one-to-clear of the same status bit. These are driven together, and the bit must read 1 afterwards. The bench also puts a command write and a blanking strobe in the same cycle and confirms that the request stays pending.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int NUM_IRQ   = 4;
  localparam int ST_LINE   = 0;
  localparam int ST_UNDER  = 1;
  localparam int ST_TERR   = 2;
  localparam int ST_RELOAD = 3;
  localparam int RQ_IMM    = 0;
  localparam int RQ_VBL    = 1;

  typedef enum logic [1:0] {
    XFER_NONE = 2'd0,
    XFER_IMM  = 2'd1,
    XFER_VBL  = 2'd2
  } xfer_e;
endpackage

// File: rtl/shr_bank.sv
module shr_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       xfer,
  output logic [NUM_REGS*DATA_W-1:0] active_flat
);
  // One shadow/active pair per register; all pairs copy on the same edge.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] active_q;
    logic              hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (xfer) active_q <= shadow_q;  // old shadow value on a collision
        if (hit)  shadow_q <= wr_data;
      end
    end

    assign active_flat[i*DATA_W +: DATA_W] = active_q;
  end
endmodule

// File: rtl/shr_reload_seq.sv
module shr_reload_seq
  import shr_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CMD_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_cmd,
  input  logic              vblank_pulse,
  output logic [1:0]        pend,
  output logic              xfer
);
  logic [1:0] pend_q, pend_n, set_bits;
  xfer_e      cause;

  // Immediate request has priority over the blanking request.
  always_comb begin
    if (pend_q[RQ_IMM])                      cause = XFER_IMM;
    else if (pend_q[RQ_VBL] && vblank_pulse) cause = XFER_VBL;
    else                                     cause = XFER_NONE;
  end

  assign set_bits = (wr_en && wr_addr == ADDR_W'(CMD_ADDR)) ? wr_cmd : 2'b00;

  always_comb begin
    pend_n = pend_q;
    unique case (cause)
      XFER_IMM: pend_n = 2'b00;                 // also satisfies blanking
      XFER_VBL: pend_n[RQ_VBL] = 1'b0;
      default:  ;
    endcase
    pend_n = pend_n | set_bits;                 // a fresh request re-arms
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 2'b00;
    else     pend_q <= pend_n;
  end

  assign pend = pend_q;
  assign xfer = (cause != XFER_NONE);
endmodule

// File: rtl/shr_irq.sv
module shr_irq
  import shr_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int EN_ADDR  = 5,
  parameter int CLR_ADDR = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NUM_IRQ-1:0] wr_bits,
  input  logic [NUM_IRQ-1:0] set_vec,
  output logic [NUM_IRQ-1:0] status,
  output logic               irq_out
);
  logic [NUM_IRQ-1:0] en_q, stat_q, clr_vec;
  logic               irq_q;

  assign clr_vec = (wr_en && wr_addr == ADDR_W'(CLR_ADDR)) ? wr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(EN_ADDR)) en_q <= wr_bits;
      stat_q <= (stat_q & ~clr_vec) | set_vec;  // set beats clear
      irq_q  <= |(stat_q & en_q);
    end
  end

  assign status  = stat_q;
  assign irq_out = irq_q;
endmodule

// File: rtl/shadow_reload_ctrl.sv
module shadow_reload_ctrl
  import shr_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       vblank_pulse,
  input  logic [NUM_IRQ-2:0]         evt_strobe,
  output logic [NUM_REGS*DATA_W-1:0] active_flat,
  output logic [1:0]                 reload_pend,
  output logic [NUM_IRQ-1:0]         irq_status,
  output logic                       irq_out
);
  localparam int CMD_ADDR = NUM_REGS;
  localparam int EN_ADDR  = NUM_REGS + 1;
  localparam int CLR_ADDR = NUM_REGS + 2;

  logic xfer;

  shr_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .xfer(xfer), .active_flat(active_flat)
  );

  shr_reload_seq #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_cmd(wr_data[1:0]), .vblank_pulse(vblank_pulse),
    .pend(reload_pend), .xfer(xfer)
  );

  shr_irq #(.ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR), .CLR_ADDR(CLR_ADDR)) u_irq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bits(wr_data[NUM_IRQ-1:0]), .set_vec({xfer, evt_strobe}),
    .status(irq_status), .irq_out(irq_out)
  );
endmodule

// File: rtl/shr_checker.sv
module shr_checker #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [3:0]                 wr_low,
  input logic                       vblank_pulse,
  input logic [NUM_REGS*DATA_W-1:0] active_flat,
  input logic [1:0]                 reload_pend,
  input logic [3:0]                 irq_status,
  input logic                       irq_out
);
  logic       cmd_req, clr_hit;
  logic [3:0] clr_mask;
  assign cmd_req  = wr_en && wr_addr == ADDR_W'(NUM_REGS) && (wr_low[1:0] != 2'b00);
  assign clr_hit  = wr_en && wr_addr == ADDR_W'(NUM_REGS + 2);
  assign clr_mask = clr_hit ? wr_low : 4'h0;

  p_hold_active_r2: assert property (@(posedge clk) disable iff (rst)
    (reload_pend == 2'b00) |=> $stable(active_flat));

  p_imm_flag_r3: assert property (@(posedge clk) disable iff (rst)
    reload_pend[0] |=> irq_status[3]);

  p_imm_clears_both_r6: assert property (@(posedge clk) disable iff (rst)
    (reload_pend[0] && !cmd_req) |=> (reload_pend == 2'b00));

  p_vbl_waits_r4: assert property (@(posedge clk) disable iff (rst)
    (reload_pend == 2'b10 && !vblank_pulse) |=> (reload_pend[1] && $stable(active_flat)));

  p_status_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(irq_status) & ~$past(clr_mask)) & ~irq_status) == 4'h0));

  p_irq_source_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (!irq_out || $past(irq_status) != 4'h0));
endmodule

bind shadow_reload_ctrl shr_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_low(wr_data[3:0]), .vblank_pulse(vblank_pulse),
  .active_flat(active_flat), .reload_pend(reload_pend),
  .irq_status(irq_status), .irq_out(irq_out)
);

// File: tb/shadow_reload_ctrl_tb_top.sv
module shadow_reload_ctrl_tb_top;
  localparam int NR = 4;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_CMD = AW'(NR);
  localparam logic [AW-1:0] A_EN  = AW'(NR + 1);
  localparam logic [AW-1:0] A_CLR = AW'(NR + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic vblank_pulse = 1'b0;
  logic [2:0] evt_strobe = 3'b000;
  logic [NR*DW-1:0] active_flat;
  logic [1:0] reload_pend;
  logic [3:0] irq_status;
  logic irq_out;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  shadow_reload_ctrl #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vblank_pulse(vblank_pulse), .evt_strobe(evt_strobe),
    .active_flat(active_flat), .reload_pend(reload_pend),
    .irq_status(irq_status), .irq_out(irq_out)
  );

  function automatic logic [DW-1:0] act(int i);
    return active_flat[i*DW +: DW];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk(active_flat == '0, "R1 active", 64'(act(0)), 64'h0);
    chk(reload_pend == 2'b00 && irq_status == 4'h0 && !irq_out, "R1 flags",
        64'({reload_pend, irq_status, irq_out}), 64'h0);
  endtask

  task automatic t_shadow_hold;
    for (int i = 0; i < NR; i++) wr(AW'(i), 32'hA000_0000 + DW'(i));
    tick(); tick();
    chk(active_flat == '0, "R2 hold", 64'(act(0)), 64'h0);
  endtask

  task automatic t_immediate;
    wr(A_CMD, 32'h1);
    chk(reload_pend == 2'b01, "R3 pend set", 64'(reload_pend), 64'h1);
    chk(act(3) == 32'h0, "R3 not yet", 64'(act(3)), 64'h0);
    tick();
    for (int i = 0; i < NR; i++)
      chk(act(i) == 32'hA000_0000 + DW'(i), "R3 copy", 64'(act(i)), 64'(32'hA000_0000 + DW'(i)));
    chk(reload_pend == 2'b00, "R3 pend clear", 64'(reload_pend), 64'h0);
    chk(irq_status[3], "R9 reload flag", 64'(irq_status), 64'h8);
  endtask

  task automatic t_irq;
    tick();
    chk(!irq_out && irq_status[3], "R11 sets while disabled", 64'({irq_status, irq_out}), 64'h10);
    wr(A_EN, 32'h8);
    chk(!irq_out, "R11 lag", 64'(irq_out), 64'h0);
    tick();
    chk(irq_out, "R11 asserted", 64'(irq_out), 64'h1);
    wr(A_CLR, 32'h8);
    chk(irq_status == 4'h0, "R10 clear", 64'(irq_status), 64'h0);
    tick();
    chk(!irq_out, "R11 deassert", 64'(irq_out), 64'h0);
    evt_strobe = 3'b101; tick(); evt_strobe = 3'b000;
    chk(irq_status == 4'h5, "R9 events", 64'(irq_status), 64'h5);
    wr(A_CLR, 32'h1);
    chk(irq_status == 4'h4, "R10 partial clear", 64'(irq_status), 64'h4);
    evt_strobe = 3'b010; wr(A_CLR, 32'h2); evt_strobe = 3'b000;
    chk(irq_status == 4'h6, "R10 set beats clear", 64'(irq_status), 64'h6);
    wr(A_CLR, 32'hF);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_vblank;
    vblank_pulse = 1'b1; tick(); vblank_pulse = 1'b0;
    chk(act(0) == 32'hA000_0000 && irq_status == 4'h0, "R4 idle vblank", 64'(irq_status), 64'h0);
    wr(4'd0, 32'h1111_0000);
    wr(A_CMD, 32'h2);
    chk(reload_pend == 2'b10, "R4 pend set", 64'(reload_pend), 64'h2);
    tick(); tick(); tick();
    chk(reload_pend == 2'b10 && act(0) == 32'hA000_0000, "R4 waiting", 64'(act(0)), 64'hA000_0000);
    wr(4'd0, 32'h2222_0000);
    vblank_pulse = 1'b1; tick(); vblank_pulse = 1'b0;
    chk(act(0) == 32'h2222_0000, "R7 latest value", 64'(act(0)), 64'h2222_0000);
    chk(reload_pend == 2'b00 && irq_status[3], "R4 served", 64'({reload_pend, irq_status}), 64'h08);
    wr(A_CLR, 32'hF);
  endtask

  task automatic t_req_with_vblank;
    wr(4'd1, 32'h3333_0001);
    vblank_pulse = 1'b1; wr(A_CMD, 32'h2); vblank_pulse = 1'b0;
    chk(reload_pend == 2'b10 && act(1) == 32'hA000_0001, "R5 not served", 64'(reload_pend), 64'h2);
    vblank_pulse = 1'b1; tick(); vblank_pulse = 1'b0;
    chk(act(1) == 32'h3333_0001, "R5 later strobe", 64'(act(1)), 64'h3333_0001);
  endtask

  task automatic t_both;
    wr(4'd2, 32'h4444_0002);
    wr(A_CMD, 32'h3);
    chk(reload_pend == 2'b11, "R6 both pend", 64'(reload_pend), 64'h3);
    tick();
    chk(reload_pend == 2'b00 && act(2) == 32'h4444_0002, "R6 imm wins", 64'(act(2)), 64'h4444_0002);
  endtask

  task automatic t_collision;
    wr(4'd3, 32'h5555_0003);
    wr(A_CMD, 32'h2);
    vblank_pulse = 1'b1; wr(4'd3, 32'h6666_0003); vblank_pulse = 1'b0;
    chk(act(3) == 32'h5555_0003, "R8 old value", 64'(act(3)), 64'h5555_0003);
    wr(A_CMD, 32'h1); tick();
    chk(act(3) == 32'h6666_0003, "R8 new kept", 64'(act(3)), 64'h6666_0003);
  endtask

  task automatic t_zero_cmd;
    wr(4'd0, 32'h7777_0000);
    wr(A_CMD, 32'h0); tick();
    chk(reload_pend == 2'b00 && act(0) == 32'h2222_0000, "R12 no start", 64'(act(0)), 64'h2222_0000);
    wr(A_CMD, 32'h2);
    wr(A_CMD, 32'h0);
    chk(reload_pend == 2'b10, "R12 no cancel", 64'(reload_pend), 64'h2);
    vblank_pulse = 1'b1; tick(); vblank_pulse = 1'b0;
    chk(act(0) == 32'h7777_0000, "R12 later serve", 64'(act(0)), 64'h7777_0000);
  endtask

  initial begin
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_shadow_hold();
    t_immediate();
    t_irq();
    t_vblank();
    t_req_with_vblank();
    t_both();
    t_collision();
    t_zero_cmd();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule